// File: doc/BRIEF.md
# Display Panel Bring-up and Power Sequencer

This block drives a display panel controller through its bring-up and its power transitions. It sits above a register access engine and hands that engine one command at a time. A command is an index-only frame, a register write, a register read or a status read. The steps come from a small internal step table. Each entry in the table is either a register write, a timed wait in milliseconds or the final index-only frame. The waits are counted in clock cycles, and the cycle count is derived from a clock-frequency parameter.

A `start` pulse first reads the panel's identification register and checks it under a mask. If the check passes, the block does a status read and then walks the whole configuration list: basic setup, interface selection, power-up, gamma, window and scroll setup, and finally the selection of the pixel-memory write register. A `pwr_on_req` or `pwr_off_req` pulse runs the power-up or power-down part of the table. This happens only when the request differs from the stored power state. While a sequence is running, `busy` is high and all new requests are dropped.

Top module: `panel_seq_top`

## Requirements
- R1: After reset, `busy`, `id_err`, `pwr_state` and `cmd_valid` are all 0.
- R2: A `start` pulse while idle first issues a register read (kind 2) of address 0x00. The identification is accepted when `(cmd_rdata & 0xFFF0) == 0x9220`.
- R3: On an identification mismatch, `id_err` goes to 1 and `busy` drops. No further command is issued and `pwr_state` is unchanged. Power requests are ignored until a later `start` succeeds.
- R4: After an accepted identification, the block issues a status read (kind 3). It then issues register writes (kind 1) in this order: 0x00=0x0001, a 10 ms wait, 0x01=0x691B, 0x02=0x0700, 0x03=0x1030, 0x04=0, 0x05=0, 0x07=0x0037, 0x08=0x0202, 0x09=0, 0x0B=0, and 0x0C=0x0110.
- R5: Every wait leaves at least its nominal length times CLK_HZ/1000 cycles between the acknowledge of the command before it and the next command.
- R6: Power-up is the following list: 0x10=0, wait 10 ms, 0x11=0, 0x12=0, wait 40 ms, 0x13=0, wait 40 ms, 0x56=0x080F, 0x10=0x4240, wait 10 ms, 0x11=0, 0x12=0x0014, wait 40 ms, 0x13=0x1319, wait 40 ms. During start-up it runs right after 0x0C.
- R7: Power-down is the first part of power-up: 0x10=0, wait 10 ms, 0x11=0, 0x12=0, wait 40 ms, 0x13=0, wait 40 ms. At its end `pwr_state` becomes 0.
- R8: After power-up, start-up writes 0x30..0x39 with 0x0302, 0x0407, 0x0304, 0x0203, 0x0706, 0x0407, 0x0706, 0, 0x0C06 and 0x0F00. It then writes 0x21=0, 0x40=0, 0x41=0, 0x42=0xDB00, 0x43=0xDB00, 0x44=0xAF00 and 0x45=0xDB00. It ends with one index-only frame (kind 0) to address 0x22, after which `pwr_state` is 1.
- R9: A power request that matches `pwr_state` starts nothing. `pwr_state` changes only at the end of a completed sequence.
- R10: `busy` is 1 from the accepted request to the end of the sequence. `start` and power requests that arrive while `busy` is 1 are ignored. This includes a request in the cycle of the last acknowledge.
- R11: `cmd_valid` stays high, with `cmd_kind`, `cmd_addr` and `cmd_wdata` stable, until `cmd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: identify and configure the panel |
| pwr_on_req | input | 1 | Pulse: request panel power on |
| pwr_off_req | input | 1 | Pulse: request panel power off |
| cmd_ack | input | 1 | Access engine finished the current command |
| cmd_rdata | input | 16 | Read result, valid with `cmd_ack` |
| cmd_valid | output | 1 | A command is offered to the access engine |
| cmd_kind | output | 2 | 0 index-only, 1 register write, 2 register read, 3 status read |
| cmd_addr | output | 8 | Register index |
| cmd_wdata | output | 16 | Register write value |
| busy | output | 1 | A sequence is running |
| id_err | output | 1 | Identification mismatch on the last start |
| pwr_state | output | 1 | Stored panel power state, 1 = on |

## Verification
The end of a sequence and a new request can fall in the same cycle. The bench's access-engine model raises `pwr_off_req` in exactly the cycle in which it acknowledges the final index-only frame of start-up. That request must be lost: no command may follow, and `pwr_state` must stay 1. Two more collisions are provoked in the middle of a power-up: a `start` and an opposite power request. In both cases the command stream is judged against the expected queue, and any extra or reordered command counts as a failure.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_WAIT = 2'd1,
    OP_IDX  = 2'd2
  } step_op_e;

  typedef enum logic [1:0] {
    CK_INDEX  = 2'd0,
    CK_WRITE  = 2'd1,
    CK_READ   = 2'd2,
    CK_STATUS = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    step_op_e    op;
    logic [7:0]  addr;
    logic [15:0] val;
  } step_t;

  localparam int ROM_DEPTH = 45;
  localparam int ROM_AW    = $clog2(ROM_DEPTH);
  localparam int MS_W      = 6;
  localparam int MAX_MS    = 40;

  // Table layout: start-up is [0..INIT_LAST], power-up is [PU_FIRST..PU_LAST],
  // power-down is the leading part [PU_FIRST..PD_LAST].
  localparam logic [ROM_AW-1:0] PU_FIRST  = ROM_AW'(12);
  localparam logic [ROM_AW-1:0] PD_LAST   = ROM_AW'(18);
  localparam logic [ROM_AW-1:0] PU_LAST   = ROM_AW'(26);
  localparam logic [ROM_AW-1:0] INIT_LAST = ROM_AW'(44);

  localparam logic [7:0]  ID_REG    = 8'h00;
  localparam logic [15:0] ID_EXPECT = 16'h9220;
  localparam logic [15:0] ID_MASK   = 16'hFFF0;

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
  import panel_seq_pkg::*;
(
  input  logic              clk,
  input  logic [ROM_AW-1:0] addr,
  output step_t             q
);

  function automatic step_t wr(input logic [7:0] a, input logic [15:0] v);
    step_t s;
    s.op = OP_WR; s.addr = a; s.val = v;
    return s;
  endfunction

  function automatic step_t wt(input int ms);
    step_t s;
    s.op = OP_WAIT; s.addr = 8'h00; s.val = 16'(ms);
    return s;
  endfunction

  function automatic step_t step_at(input logic [ROM_AW-1:0] i);
    step_t s;
    case (i)
      6'd0:  s = wr(8'h00, 16'h0001);
      6'd1:  s = wt(10);
      6'd2:  s = wr(8'h01, 16'h691B);
      6'd3:  s = wr(8'h02, 16'h0700);
      6'd4:  s = wr(8'h03, 16'h1030);
      6'd5:  s = wr(8'h04, 16'h0000);
      6'd6:  s = wr(8'h05, 16'h0000);
      6'd7:  s = wr(8'h07, 16'h0037);
      6'd8:  s = wr(8'h08, 16'h0202);
      6'd9:  s = wr(8'h09, 16'h0000);
      6'd10: s = wr(8'h0B, 16'h0000);
      6'd11: s = wr(8'h0C, 16'h0110);
      6'd12: s = wr(8'h10, 16'h0000);
      6'd13: s = wt(10);
      6'd14: s = wr(8'h11, 16'h0000);
      6'd15: s = wr(8'h12, 16'h0000);
      6'd16: s = wt(40);
      6'd17: s = wr(8'h13, 16'h0000);
      6'd18: s = wt(40);
      6'd19: s = wr(8'h56, 16'h080F);
      6'd20: s = wr(8'h10, 16'h4240);
      6'd21: s = wt(10);
      6'd22: s = wr(8'h11, 16'h0000);
      6'd23: s = wr(8'h12, 16'h0014);
      6'd24: s = wt(40);
      6'd25: s = wr(8'h13, 16'h1319);
      6'd26: s = wt(40);
      6'd27: s = wr(8'h30, 16'h0302);
      6'd28: s = wr(8'h31, 16'h0407);
      6'd29: s = wr(8'h32, 16'h0304);
      6'd30: s = wr(8'h33, 16'h0203);
      6'd31: s = wr(8'h34, 16'h0706);
      6'd32: s = wr(8'h35, 16'h0407);
      6'd33: s = wr(8'h36, 16'h0706);
      6'd34: s = wr(8'h37, 16'h0000);
      6'd35: s = wr(8'h38, 16'h0C06);
      6'd36: s = wr(8'h39, 16'h0F00);
      6'd37: s = wr(8'h21, 16'h0000);
      6'd38: s = wr(8'h40, 16'h0000);
      6'd39: s = wr(8'h41, 16'h0000);
      6'd40: s = wr(8'h42, 16'hDB00);
      6'd41: s = wr(8'h43, 16'hDB00);
      6'd42: s = wr(8'h44, 16'hAF00);
      6'd43: s = wr(8'h45, 16'hDB00);
      6'd44: begin s.op = OP_IDX; s.addr = 8'h22; s.val = 16'h0000; end
      default: s = wt(1);
    endcase
    return s;
  endfunction

  always_ff @(posedge clk) begin
    q <= step_at(addr);
  end

endmodule

// File: rtl/panel_ms_timer.sv
module panel_ms_timer #(
  parameter int CYC_PER_MS = 1000,
  parameter int MAX_MS     = 40,
  parameter int MS_W       = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            running
);

  localparam int CW = $clog2(MAX_MS * CYC_PER_MS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= CW'(ms) * CW'(CYC_PER_MS);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign running = (cnt != '0);

endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
  import panel_seq_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        pwr_on_req,
  input  logic        pwr_off_req,
  input  logic        cmd_ack,
  input  logic [15:0] cmd_rdata,
  output logic        cmd_valid,
  output logic [1:0]  cmd_kind,
  output logic [7:0]  cmd_addr,
  output logic [15:0] cmd_wdata,
  output logic        busy,
  output logic        id_err,
  output logic        pwr_state
);

  localparam int CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

  typedef enum logic [2:0] {
    S_IDLE, S_ID, S_STAT, S_FETCH, S_EXEC, S_CMD, S_WAIT
  } st_e;

  st_e               st;
  logic [ROM_AW-1:0] pc, end_pc;
  logic              target, ready;
  step_t             rom_q;
  logic              tmr_load, tmr_running;
  logic              last_step;

  panel_seq_rom u_rom (
    .clk  (clk),
    .addr (pc),
    .q    (rom_q)
  );

  assign tmr_load = (st == S_EXEC) && (rom_q.op == OP_WAIT);

  panel_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MAX_MS     (MAX_MS),
    .MS_W       (MS_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .ms      (rom_q.val[MS_W-1:0]),
    .running (tmr_running)
  );

  assign last_step = (pc == end_pc);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pc        <= '0;
      end_pc    <= '0;
      target    <= 1'b0;
      ready     <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_kind  <= CK_INDEX;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      busy      <= 1'b0;
      id_err    <= 1'b0;
      pwr_state <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            id_err    <= 1'b0;
            ready     <= 1'b0;
            busy      <= 1'b1;
            cmd_valid <= 1'b1;
            cmd_kind  <= CK_READ;
            cmd_addr  <= ID_REG;
            cmd_wdata <= '0;
            st        <= S_ID;
          end else if (ready && pwr_on_req && !pwr_state) begin
            busy   <= 1'b1;
            pc     <= PU_FIRST;
            end_pc <= PU_LAST;
            target <= 1'b1;
            st     <= S_FETCH;
          end else if (ready && pwr_off_req && pwr_state) begin
            busy   <= 1'b1;
            pc     <= PU_FIRST;
            end_pc <= PD_LAST;
            target <= 1'b0;
            st     <= S_FETCH;
          end
        end
        S_ID: begin
          if (cmd_ack) begin
            if ((cmd_rdata & ID_MASK) == ID_EXPECT) begin
              cmd_kind <= CK_STATUS;
              st       <= S_STAT;
            end else begin
              cmd_valid <= 1'b0;
              id_err    <= 1'b1;
              busy      <= 1'b0;
              st        <= S_IDLE;
            end
          end
        end
        S_STAT: begin
          if (cmd_ack) begin
            cmd_valid <= 1'b0;
            pc        <= '0;
            end_pc    <= INIT_LAST;
            target    <= 1'b1;
            st        <= S_FETCH;
          end
        end
        S_FETCH: st <= S_EXEC;
        S_EXEC: begin
          if (rom_q.op == OP_WAIT) begin
            st <= S_WAIT;
          end else begin
            cmd_valid <= 1'b1;
            cmd_kind  <= (rom_q.op == OP_IDX) ? CK_INDEX : CK_WRITE;
            cmd_addr  <= rom_q.addr;
            cmd_wdata <= rom_q.val;
            st        <= S_CMD;
          end
        end
        S_CMD, S_WAIT: begin
          if ((st == S_CMD && cmd_ack) || (st == S_WAIT && !tmr_running)) begin
            cmd_valid <= 1'b0;
            if (last_step) begin
              busy      <= 1'b0;
              pwr_state <= target;
              ready     <= 1'b1;
              st        <= S_IDLE;
            end else begin
              pc <= pc + 1'b1;
              st <= S_FETCH;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_wdata))); // R11
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    id_err |-> (!cmd_valid && !busy)); // R3
  AST_PWR_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(pwr_state)); // R9
  AST_WAIT_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    tmr_running |-> !cmd_valid); // R5

endmodule

// File: tb/tb_panel_seq_top.sv
module tb_panel_seq_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 8000;
  localparam int CPM        = CLK_HZ / 1000;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, on_req = 1'b0, off_req_tb = 1'b0, inj_req = 1'b0;
  logic        cmd_ack = 1'b0;
  logic [15:0] cmd_rdata = 16'h0;
  logic        cmd_valid, busy, id_err, pwr_state;
  logic [1:0]  cmd_kind;
  logic [7:0]  cmd_addr;
  logic [15:0] cmd_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_seq_top #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst(rst), .start(start), .pwr_on_req(on_req),
    .pwr_off_req(off_req_tb | inj_req), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .busy(busy), .id_err(id_err), .pwr_state(pwr_state)
  );

  typedef struct {
    int    kind;
    int    addr;
    int    data;
    int    wms;
    string req;
  } exp_t;

  exp_t        q[$];
  int          total = 0, bad = 0;
  int          cyc = 0, lat = 0, t_ack = -1;
  logic        seen = 1'b0, inject = 1'b0;
  logic [15:0] id_value = 16'h0;
  logic [1:0]  k0;
  logic [7:0]  a0;
  logic [15:0] d0;

  function automatic void chk(input bit ok, input string req, input string what,
                              input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endfunction

  function automatic void push(input int k, input int a, input int d, input int w, input string r);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d; e.wms = w; e.req = r;
    q.push_back(e);
  endfunction

  // R6: power-up list; trailing 40 ms wait is carried by whatever follows
  function automatic void push_up();
    push(1, 'h10, 'h0000, 0,  "R6");
    push(1, 'h11, 'h0000, 10, "R6");
    push(1, 'h12, 'h0000, 0,  "R6");
    push(1, 'h13, 'h0000, 40, "R6");
    push(1, 'h56, 'h080F, 40, "R6");
    push(1, 'h10, 'h4240, 0,  "R6");
    push(1, 'h11, 'h0000, 10, "R6");
    push(1, 'h12, 'h0014, 0,  "R6");
    push(1, 'h13, 'h1319, 40, "R6");
  endfunction

  // R7: power-down list
  function automatic void push_down();
    push(1, 'h10, 'h0000, 0,  "R7");
    push(1, 'h11, 'h0000, 10, "R7");
    push(1, 'h12, 'h0000, 0,  "R7");
    push(1, 'h13, 'h0000, 40, "R7");
  endfunction

  function automatic void push_init();
    int gv[10] = '{'h0302, 'h0407, 'h0304, 'h0203, 'h0706, 'h0407, 'h0706, 'h0000, 'h0C06, 'h0F00};
    push(2, 'h00, 0, 0, "R2");
    push(3, 'h00, 0, 0, "R4");
    push(1, 'h00, 'h0001, 0,  "R4");
    push(1, 'h01, 'h691B, 10, "R4");
    push(1, 'h02, 'h0700, 0,  "R4");
    push(1, 'h03, 'h1030, 0,  "R4");
    push(1, 'h04, 'h0000, 0,  "R4");
    push(1, 'h05, 'h0000, 0,  "R4");
    push(1, 'h07, 'h0037, 0,  "R4");
    push(1, 'h08, 'h0202, 0,  "R4");
    push(1, 'h09, 'h0000, 0,  "R4");
    push(1, 'h0B, 'h0000, 0,  "R4");
    push(1, 'h0C, 'h0110, 0,  "R4");
    push_up();
    for (int i = 0; i < 10; i++) push(1, 'h30 + i, gv[i], (i == 0) ? 40 : 0, "R8");
    push(1, 'h21, 'h0000, 0, "R8");
    push(1, 'h40, 'h0000, 0, "R8");
    push(1, 'h41, 'h0000, 0, "R8");
    push(1, 'h42, 'hDB00, 0, "R8");
    push(1, 'h43, 'hDB00, 0, "R8");
    push(1, 'h44, 'hAF00, 0, "R8");
    push(1, 'h45, 'hDB00, 0, "R8");
    push(0, 'h22, 0, 0, "R8");
  endfunction

  // Access-engine model and command-stream reference, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    inj_req <= 1'b0;
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (cmd_ack) begin
      cmd_ack <= 1'b0;
      lat = 0;
      seen = 1'b0;
    end else if (cmd_valid && !rst) begin
      if (!seen) begin
        seen = 1'b1;
        k0 = cmd_kind; a0 = cmd_addr; d0 = cmd_wdata;
        if (t_ack >= 0 && q.size() > 0) begin
          chk((cyc - t_ack) >= q[0].wms * CPM, "R5", "gap below wait", cyc - t_ack, q[0].wms * CPM);
          chk((cyc - t_ack) <= q[0].wms * CPM + 12, "R5", "gap too long", cyc - t_ack, q[0].wms * CPM + 12);
        end
      end
      lat++;
      if (lat == LAT) begin
        cmd_ack   <= 1'b1;
        cmd_rdata <= id_value;
        t_ack = cyc;
        chk(k0 == cmd_kind && a0 == cmd_addr && d0 == cmd_wdata, "R11", "fields moved",
            {cmd_kind, cmd_addr, cmd_wdata}, {k0, a0, d0});
        if (q.size() == 0) begin
          chk(1'b0, "R10", "unexpected command", {cmd_kind, cmd_addr}, 0);
        end else begin
          chk(int'(cmd_kind) == q[0].kind, q[0].req, "kind", cmd_kind, q[0].kind);
          chk(int'(cmd_addr) == q[0].addr, q[0].req, "addr", cmd_addr, q[0].addr);
          if (q[0].kind == 1)
            chk(int'(cmd_wdata) == q[0].data, q[0].req, "data", cmd_wdata, q[0].data);
          void'(q.pop_front());
          if (q.size() == 0 && inject) begin
            inj_req <= 1'b1;
            inject = 1'b0;
          end
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); start <= 1'b1; t_ack = -1;
    @(negedge clk); start <= 1'b0;
  endtask

  task automatic pulse_on();
    @(negedge clk); on_req <= 1'b1; t_ack = -1;
    @(negedge clk); on_req <= 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk); off_req_tb <= 1'b1; t_ack = -1;
    @(negedge clk); off_req_tb <= 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_valid || busy) ok = 1'b0;
    end
    chk(ok, req, "activity while it should be ignored", {cmd_valid, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(busy == 0 && id_err == 0 && pwr_state == 0 && cmd_valid == 0, "R1", "reset state",
        {busy, id_err, pwr_state, cmd_valid}, 0);

    // power request before any successful start
    pulse_on();
    quiet(30, "R3");

    // identification mismatch
    id_value = 16'h9310;
    push(2, 'h00, 0, 0, "R2");
    pulse_start();
    wait_idle();
    repeat (2) @(negedge clk);
    chk(id_err == 1, "R3", "id_err after mismatch", id_err, 1);
    chk(pwr_state == 0, "R3", "pwr_state after mismatch", pwr_state, 0);
    chk(q.size() == 0, "R2", "pending commands", q.size(), 0);
    quiet(40, "R3");
    pulse_on();
    quiet(30, "R3");

    // accepted identification (low nibble masked), full start-up
    id_value = 16'h922F;
    push_init();
    inject = 1'b1;
    pulse_start();
    repeat (2) @(negedge clk);
    chk(busy == 1, "R10", "busy during start-up", busy, 1);
    wait_idle();
    chk(q.size() == 0, "R8", "pending start-up commands", q.size(), 0);
    chk(id_err == 0, "R2", "id_err after match", id_err, 0);
    chk(pwr_state == 1, "R8", "pwr_state after start-up", pwr_state, 1);
    quiet(40, "R10");
    chk(pwr_state == 1, "R10", "pwr_state after collided off request", pwr_state, 1);

    // matching request ignored
    pulse_on();
    quiet(30, "R9");
    chk(pwr_state == 1, "R9", "pwr_state after redundant on", pwr_state, 1);

    // power down
    push_down();
    pulse_off();
    wait_idle();
    chk(q.size() == 0, "R7", "pending power-down commands", q.size(), 0);
    chk(pwr_state == 0, "R7", "pwr_state after power-down", pwr_state, 0);
    pulse_off();
    quiet(30, "R9");

    // power up with collisions mid-sequence
    push_up();
    pulse_on();
    repeat (20) @(negedge clk);
    pulse_start();
    pulse_off();
    wait_idle();
    chk(q.size() == 0, "R6", "pending power-up commands", q.size(), 0);
    chk(pwr_state == 1, "R6", "pwr_state after power-up", pwr_state, 1);
    chk(id_err == 0, "R10", "id_err after ignored start", id_err, 0);
    quiet(20, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule